// File: doc/BRIEF.md
# Multiplexed Teaching Logic Tile

This block packs five small teaching circuits behind a single shared pin set: a two-input gate bank, a ripple frequency divider fed by a fast oscillator clock, a dual flip-flop phase-frequency detector, a D/T flip-flop pair and a 4-bit event counter. A 3-bit mode input chooses which circuit drives the 8-bit output bus. The five shared sub-inputs take on a different meaning for each circuit. Every circuit runs all the time, whatever the mode, so switching the mode only changes which one is seen on the bus.

A 4-bit monitor bus bypasses the mode selection. It always shows the detector's UP and DOWN signals, a divide-by-1024 tap of the divider and the raw oscillator clock. For simulation, the on-chip inverter ring is replaced by the `osc_clk_i` input, which is gated by the ring-enable sub-input before it reaches the divider. `rst_ni` is a power-on reset that clears every stored bit.

Top module: `edu_tile`

## Requirements
- R1: `mode_sel_i` encodings are 0 gate bank, 1 divider, 2 phase detector, 3 flip-flop pair and 4 counter. Encodings 5, 6 and 7 force all eight bus bits to 0.
- R2: In mode 0, with A on `sub_i[0]` and B on `sub_i[1]`, the bus carries NOT A on bit 1, AND on bit 2, OR on bit 3, XOR on bit 4, NAND on bit 5, NOR on bit 6 and XNOR on bit 7.
- R3: In mode 0, bus bit 0 copies the gate chosen by `sub_i[4:2]`. Value 0 picks NOT A and values 1 to 6 pick bus bits 2 to 7 in that order. Value 7 gives 0.
- R4: While `sub_i[2]` is 1, the 24-bit divider counts rising edges of `osc_clk_i`. In mode 1, bus bit 0 shows counter bit 6, 12, 20 or 23 for `sub_i[1:0]` = 00, 01, 10 or 11, and the other bus bits are 0.
- R5: While `sub_i[2]` is 0, the divider holds its count.
- R6: `mon_o[3]` always follows the ungated `osc_clk_i`, and `mon_o[2]` always shows divider bit 9 (divide by 1024).
- R7: A rising edge on `sub_i[0]` (reference) sets UP and a rising edge on `sub_i[1]` (feedback) sets DOWN. When both are set, both clear at once, so UP and DOWN are never seen high together.
- R8: In mode 2, UP drives bus bit 0 and DOWN drives bus bit 1. UP and DOWN also drive `mon_o[0]` and `mon_o[1]` in every mode.
- R9: In mode 3, a rising edge on `sub_i[0]` loads `sub_i[1]` into the D flip-flop. Its Q drives bus bit 0 and its inverse drives bus bit 1.
- R10: In mode 3, the T flip-flop on bus bit 2 toggles on a rising edge of `sub_i[0]` when `sub_i[2]` is 1. A 1 on `sub_i[3]` clears both flip-flops at once, without a clock edge.
- R11: In mode 4, bus bits 3:0 show a count that advances on each rising edge of `sub_i[0]` and wraps from 15 to 0. A 1 on `sub_i[1]` clears it at once. Bus bits 7:4 are 0.
- R12: Every circuit keeps running in every mode, and the bus bits the selected circuit does not use are 0.
- R13: While `rst_ni` is 0, the divider, the detector, both flip-flops and the counter are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Fast clock standing in for the inverter ring |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| mode_sel_i | input | 3 | Selects which circuit drives the output bus |
| sub_i | input | 5 | Shared sub-inputs, meaning set by the mode |
| bus_o | output | 8 | Output bus of the selected circuit |
| mon_o | output | 4 | Monitor bus: {raw oscillator, divide-by-1024, DOWN, UP} |

## Verification
The hardest state to reach from the ports is a known position of the high divider taps. Bit 12 needs thousands of oscillator edges, and the upper taps need more than a million. The stimulus enables the ring for an exact number of oscillator cycles and then drops the enable so the count freezes. It then steps `sub_i[1:0]` through every tap and compares each one with the count shifted down by that tap's position. The detector's mutual clear is brief, so the bench sets it up on purpose: it raises one clock and then the other, in both orders. After each step it checks that both outputs have gone back to 0. A separate property confirms that UP and DOWN are never sampled high together.

// File: rtl/edu_tile_pkg.sv
`timescale 1ns/1ps
package edu_tile_pkg;

  typedef enum logic [2:0] {
    MODE_GATE = 3'd0,
    MODE_DIV  = 3'd1,
    MODE_PFD  = 3'd2,
    MODE_FF   = 3'd3,
    MODE_CNT  = 3'd4
  } tile_mode_e;

  localparam int GATE_N = 7;

  // index 0 = NOT A, then AND, OR, XOR, NAND, NOR, XNOR
  function automatic logic [GATE_N-1:0] gate_bank(input logic a, input logic b);
    return {~(a ^ b), ~(a | b), ~(a & b), a ^ b, a | b, a & b, ~a};
  endfunction

  // select 7 lands on the padded zero bit
  function automatic logic gate_pick(input logic [GATE_N-1:0] bank, input logic [2:0] sel);
    logic [7:0] ext;
    ext = {{(8-GATE_N){1'b0}}, bank};
    return ext[sel];
  endfunction

endpackage

// File: rtl/edu_gate_bank.sv
`timescale 1ns/1ps
module edu_gate_bank
  import edu_tile_pkg::*;
(
  input  logic              a_i,
  input  logic              b_i,
  input  logic [2:0]        sel_i,
  output logic [GATE_N-1:0] bank_o,
  output logic              pick_o
);

  always_comb begin
    bank_o = gate_bank(a_i, b_i);
    pick_o = gate_pick(bank_o, sel_i);
  end

endmodule

// File: rtl/edu_ripple_div.sv
`timescale 1ns/1ps
module edu_ripple_div #(
  parameter int DIV_W   = 24,
  parameter int TAP_A   = 6,
  parameter int TAP_B   = 12,
  parameter int TAP_C   = 20,
  parameter int TAP_D   = 23,
  parameter int MON_BIT = 9
) (
  input  logic       osc_clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] tap_sel_i,
  output logic       tap_o,
  output logic       mon_o
);

  logic             gclk;
  logic [DIV_W-1:0] stage_q;

  assign gclk = osc_clk_i & en_i;

  for (genvar i = 0; i < DIV_W; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge gclk or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= 1'b0;
        else         stage_q[0] <= ~stage_q[0];
      end
    end else begin : g_rest
      always_ff @(negedge stage_q[i-1] or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= 1'b0;
        else         stage_q[i] <= ~stage_q[i];
      end
    end
  end

  always_comb begin
    case (tap_sel_i)
      2'b00:   tap_o = stage_q[TAP_A];
      2'b01:   tap_o = stage_q[TAP_B];
      2'b10:   tap_o = stage_q[TAP_C];
      default: tap_o = stage_q[TAP_D];
    endcase
  end

  assign mon_o = stage_q[MON_BIT];

endmodule

// File: rtl/edu_pfd.sv
`timescale 1ns/1ps
module edu_pfd (
  input  logic rst_ni,
  input  logic ref_i,
  input  logic fb_i,
  output logic up_o,
  output logic dn_o,
  output logic clr_o
);

  logic up_q;
  logic dn_q;

  assign clr_o = (up_q & dn_q) | ~rst_ni;

  always_ff @(posedge ref_i or posedge clr_o) begin
    if (clr_o) up_q <= 1'b0;
    else       up_q <= 1'b1;
  end

  always_ff @(posedge fb_i or posedge clr_o) begin
    if (clr_o) dn_q <= 1'b0;
    else       dn_q <= 1'b1;
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

endmodule

// File: rtl/edu_ff_pair.sv
`timescale 1ns/1ps
module edu_ff_pair (
  input  logic rst_ni,
  input  logic clk_i,
  input  logic d_i,
  input  logic t_en_i,
  input  logic clr_i,
  output logic d_q_o,
  output logic t_q_o
);

  logic wipe;
  assign wipe = clr_i | ~rst_ni;

  always_ff @(posedge clk_i or posedge wipe) begin
    if (wipe) begin
      d_q_o <= 1'b0;
      t_q_o <= 1'b0;
    end else begin
      d_q_o <= d_i;
      if (t_en_i) t_q_o <= ~t_q_o;
    end
  end

endmodule

// File: rtl/edu_event_cnt.sv
`timescale 1ns/1ps
module edu_event_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             rst_ni,
  input  logic             clk_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic wipe;
  assign wipe = clr_i | ~rst_ni;

  always_ff @(posedge clk_i or posedge wipe) begin
    if (wipe) cnt_o <= '0;
    else      cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/edu_tile.sv
`timescale 1ns/1ps
module edu_tile
  import edu_tile_pkg::*;
#(
  parameter int DIV_W   = 24,
  parameter int TAP_A   = 6,
  parameter int TAP_B   = 12,
  parameter int TAP_C   = 20,
  parameter int TAP_D   = 23,
  parameter int MON_BIT = 9,
  parameter int CNT_W   = 4
) (
  input  logic       osc_clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_sel_i,
  input  logic [4:0] sub_i,
  output logic [7:0] bus_o,
  output logic [3:0] mon_o
);

  localparam int BUS_W = 8;

  logic [GATE_N-1:0] gate_bank_w;
  logic              gate_pick_w;
  logic              div_tap_w;
  logic              div_mon_w;
  logic              pfd_up_w;
  logic              pfd_dn_w;
  logic              pfd_clr_w;
  logic              ff_d_w;
  logic              ff_t_w;
  logic [CNT_W-1:0]  cnt_w;

  edu_gate_bank u_gates (
    .a_i    (sub_i[0]),
    .b_i    (sub_i[1]),
    .sel_i  (sub_i[4:2]),
    .bank_o (gate_bank_w),
    .pick_o (gate_pick_w)
  );

  edu_ripple_div #(
    .DIV_W(DIV_W), .TAP_A(TAP_A), .TAP_B(TAP_B),
    .TAP_C(TAP_C), .TAP_D(TAP_D), .MON_BIT(MON_BIT)
  ) u_div (
    .osc_clk_i (osc_clk_i),
    .rst_ni    (rst_ni),
    .en_i      (sub_i[2]),
    .tap_sel_i (sub_i[1:0]),
    .tap_o     (div_tap_w),
    .mon_o     (div_mon_w)
  );

  edu_pfd u_pfd (
    .rst_ni (rst_ni),
    .ref_i  (sub_i[0]),
    .fb_i   (sub_i[1]),
    .up_o   (pfd_up_w),
    .dn_o   (pfd_dn_w),
    .clr_o  (pfd_clr_w)
  );

  edu_ff_pair u_ff (
    .rst_ni (rst_ni),
    .clk_i  (sub_i[0]),
    .d_i    (sub_i[1]),
    .t_en_i (sub_i[2]),
    .clr_i  (sub_i[3]),
    .d_q_o  (ff_d_w),
    .t_q_o  (ff_t_w)
  );

  edu_event_cnt #(.CNT_W(CNT_W)) u_cnt (
    .rst_ni (rst_ni),
    .clk_i  (sub_i[0]),
    .clr_i  (sub_i[1]),
    .cnt_o  (cnt_w)
  );

  always_comb begin
    bus_o = '0;
    case (mode_sel_i)
      MODE_GATE: bus_o = {gate_bank_w, gate_pick_w};
      MODE_DIV:  bus_o = {{(BUS_W-1){1'b0}}, div_tap_w};
      MODE_PFD:  bus_o = {{(BUS_W-2){1'b0}}, pfd_dn_w, pfd_up_w};
      MODE_FF:   bus_o = {{(BUS_W-3){1'b0}}, ff_t_w, ~ff_d_w, ff_d_w};
      MODE_CNT:  bus_o = {{(BUS_W-CNT_W){1'b0}}, cnt_w};
      default:   bus_o = '0;
    endcase
  end

  assign mon_o = {osc_clk_i, div_mon_w, pfd_dn_w, pfd_up_w};

  logic unused_clr;
  assign unused_clr = pfd_clr_w;

endmodule

// File: rtl/edu_tile_chk.sv
`timescale 1ns/1ps
module edu_tile_chk (
  input logic       osc_clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_sel_i,
  input logic [2:0] sub_hi,
  input logic [7:0] bus_o,
  input logic [2:0] mon_lo
);

  // R1: reserved encodings give an all-zero bus
  p_reserved_zero_r1: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (mode_sel_i >= 3'd5) |-> (bus_o == 8'h00));

  // R3: bit 0 equals the bus bit of the picked gate
  p_gate_pick_r3: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (mode_sel_i == 3'd0 && sub_hi != 3'd7) |-> (bus_o[0] == bus_o[int'(sub_hi) + 1]));

  // R5: no divider movement while the ring is off
  p_div_frozen_r5: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    $past(!sub_hi[0]) |-> $stable(mon_lo[2]));

  // R7: UP and DOWN never seen together
  p_pfd_exclusive_r7: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    !(mon_lo[0] && mon_lo[1]));

  // R8: detector bus bits match the monitor pins
  p_pfd_mirror_r8: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (mode_sel_i == 3'd2) |-> (bus_o[1:0] == mon_lo[1:0]));

  // R9: D flip-flop outputs are complementary
  p_dff_compl_r9: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (mode_sel_i == 3'd3) |-> (bus_o[1] == !bus_o[0]));

  // R11: counter mode keeps upper bus bits low
  p_cnt_upper_r11: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (mode_sel_i == 3'd4) |-> (bus_o[7:4] == 4'h0));

endmodule

bind edu_tile edu_tile_chk u_chk (
  .osc_clk_i  (osc_clk_i),
  .rst_ni     (rst_ni),
  .mode_sel_i (mode_sel_i),
  .sub_hi     (sub_i[4:2]),
  .bus_o      (bus_o),
  .mon_lo     (mon_o[2:0])
);

// File: tb/tb_edu_tile.sv
`timescale 1ns/1ps
module tb_edu_tile;

  logic       clk;
  logic       rst_n;
  logic [2:0] mode;
  logic [4:0] sub;
  logic [7:0] bus;
  logic [3:0] mon;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  edu_tile dut (
    .osc_clk_i  (clk),
    .rst_ni     (rst_n),
    .mode_sel_i (mode),
    .sub_i      (sub),
    .bus_o      (bus),
    .mon_o      (mon)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {gate select, B, A, expected bus} for R2 and R3
  localparam int NVEC = 16;
  localparam logic [12:0] VEC [NVEC] = '{
    {3'd0, 1'b0, 1'b0, 8'hE3}, {3'd4, 1'b0, 1'b0, 8'hE3},
    {3'd3, 1'b0, 1'b0, 8'hE2}, {3'd7, 1'b0, 1'b0, 8'hE2},
    {3'd0, 1'b0, 1'b1, 8'h38}, {3'd2, 1'b0, 1'b1, 8'h39},
    {3'd5, 1'b0, 1'b1, 8'h38}, {3'd6, 1'b0, 1'b1, 8'h38},
    {3'd0, 1'b1, 1'b0, 8'h3B}, {3'd1, 1'b1, 1'b0, 8'h3A},
    {3'd3, 1'b1, 1'b0, 8'h3B}, {3'd7, 1'b1, 1'b0, 8'h3A},
    {3'd1, 1'b1, 1'b1, 8'h8D}, {3'd6, 1'b1, 1'b1, 8'h8D},
    {3'd4, 1'b1, 1'b1, 8'h8C}, {3'd7, 1'b1, 1'b1, 8'h8C}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sub   = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse();
    @(negedge clk) sub[0] = 1'b1;
    @(negedge clk) sub[0] = 1'b0;
    #1;
  endtask

  initial begin
    int n;
    rst_n = 1'b0;
    mode  = 3'd4;
    sub   = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R13 counter cleared", bus, 8'h00);
    chk("R13 monitor cleared", {5'b0, mon[2:0]}, 8'h00);
    mode = 3'd3;
    #1;
    chk("R13 flip-flops cleared", bus, 8'h02);
    @(negedge clk) rst_n = 1'b1;

    // R2 / R3 vector walk
    mode = 3'd0;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk) sub = VEC[i][12:8];
      #1;
      chk($sformatf("R2 R3 vector %0d", i), bus, VEC[i][7:0]);
    end

    // R1 reserved encodings
    for (int m = 5; m < 8; m++) begin
      @(negedge clk);
      mode = 3'(m);
      sub  = 5'h1B;
      #1;
      chk($sformatf("R1 mode %0d", m), bus, 8'h00);
    end

    // R11 counter
    do_reset();
    mode = 3'd4;
    repeat (3) pulse();
    chk("R11 count 3", bus, 8'h03);
    repeat (12) pulse();
    chk("R11 count 15", bus, 8'h0F);
    pulse();
    chk("R11 wrap to 0", bus, 8'h00);
    repeat (2) pulse();
    @(negedge clk) sub[1] = 1'b1;
    #1;
    chk("R11 async clear", bus, 8'h00);
    @(negedge clk) sub[1] = 1'b0;

    // R12 counter runs while another mode is shown
    mode = 3'd3;
    repeat (2) pulse();
    mode = 3'd4;
    #1;
    chk("R12 counter advanced unseen", bus, 8'h02);

    // R9 / R10 flip-flop pair
    mode = 3'd3;
    @(negedge clk) sub[3] = 1'b1;
    #1;
    chk("R10 clear", bus, 8'h02);
    @(negedge clk) begin sub[3] = 1'b0; sub[1] = 1'b1; sub[2] = 1'b0; end
    pulse();
    chk("R9 load 1", bus, 8'h01);
    @(negedge clk) sub[2] = 1'b1;
    pulse();
    chk("R10 toggle up", bus, 8'h05);
    pulse();
    chk("R10 toggle down", bus, 8'h01);
    @(negedge clk) begin sub[1] = 1'b0; sub[2] = 1'b0; end
    pulse();
    chk("R9 load 0", bus, 8'h02);
    @(negedge clk) sub[2] = 1'b1;
    pulse();
    chk("R10 toggle with D 0", bus, 8'h06);
    @(negedge clk) sub[3] = 1'b1;
    #1;
    chk("R10 async clear", bus, 8'h02);
    @(negedge clk) sub = '0;

    // R7 / R8 phase detector
    do_reset();
    mode = 3'd2;
    @(negedge clk) sub[0] = 1'b1;
    #1;
    chk("R7 R8 ref leads UP", bus, 8'h01);
    chk("R8 monitor UP", {4'b0, mon[1:0]}, 8'h01);
    @(negedge clk) sub[1] = 1'b1;
    #1;
    chk("R7 mutual clear", bus, 8'h00);
    @(negedge clk) sub = '0;
    @(negedge clk) sub[1] = 1'b1;
    #1;
    chk("R7 R8 fb leads DOWN", bus, 8'h02);
    chk("R8 monitor DOWN", {4'b0, mon[1:0]}, 8'h02);
    @(negedge clk) sub[0] = 1'b1;
    #1;
    chk("R7 mutual clear reverse", bus, 8'h00);
    @(negedge clk) sub = '0;
    mode = 3'd0;
    @(negedge clk) sub[0] = 1'b1;
    #1;
    chk("R8 R12 monitor live in mode 0", {4'b0, mon[1:0]}, 8'h01);
    chk("R12 gate bus unaffected", bus, 8'h38);
    @(negedge clk) sub = '0;

    // R4 / R5 / R6 divider
    do_reset();
    mode = 3'd1;
    @(negedge clk) sub = 5'b00100;
    n = 5000;
    repeat (5000) @(posedge clk);
    @(negedge clk) sub[2] = 1'b0;
    for (int k = 0; k < 4; k++) begin
      int tap;
      tap = (k == 0) ? 6 : (k == 1) ? 12 : (k == 2) ? 20 : 23;
      sub[1:0] = 2'(k);
      #1;
      chk($sformatf("R4 tap %0d after %0d", tap, n), bus, {7'b0, 1'((n >> tap) & 1)});
    end
    chk("R6 divide by 1024", {7'b0, mon[2]}, {7'b0, 1'((n >> 9) & 1)});
    @(negedge clk) sub[1:0] = 2'b00;
    repeat (400) @(negedge clk);
    #1;
    chk("R5 frozen tap", bus, {7'b0, 1'((n >> 6) & 1)});
    @(negedge clk) sub[2] = 1'b1;
    repeat (3000) @(posedge clk);
    @(negedge clk) sub[2] = 1'b0;
    n = 8000;
    #1;
    chk("R4 tap 6 after 8000", bus, {7'b0, 1'((n >> 6) & 1)});
    sub[1:0] = 2'b01;
    #1;
    chk("R4 tap 12 after 8000", bus, {7'b0, 1'((n >> 12) & 1)});
    chk("R6 divide by 1024 after 8000", {7'b0, mon[2]}, {7'b0, 1'((n >> 9) & 1)});
    @(negedge clk);
    #1;
    chk("R6 raw low", {7'b0, mon[3]}, 8'h00);
    @(posedge clk);
    #1;
    chk("R6 raw high", {7'b0, mon[3]}, 8'h01);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule